// File: doc/BRIEF.md
# In-Order Retirement Queue with Precise Exceptions

This block tracks instructions between dispatch and retirement in an out-of-order core. Dispatch claims up to two slots per cycle in program order and receives a slot tag for each. Execution units later report back against that tag, each report carrying either a result value or a fault flag. Each slot owns one rename buffer, so the tag is also the rename register index. Results land there in any order, and the queue drains them into the architectural register file strictly oldest-first, at most two per cycle.

A fault recorded against a younger slot stays silent until that slot becomes the oldest. It is then reported on a one-cycle exception pulse carrying the slot tag. The faulting slot is not retired and writes nothing. Every slot still in the queue is discarded, and with it every rename buffer still in use. An architectural read port lets the surrounding logic see the committed register state.

Top module: `rob_retire_queue`

## Requirements
- R1: After reset the occupancy is 0, no retire or exception output is active, the next allocation tag is 0, a request for two slots is not stalled, and every architectural register reads 0.
- R2: Slot tags are handed out in program order. The tag of the first slot requested in a cycle appears on `alloc_tag[IW-1:0]` and the tag of the second on `alloc_tag[2*IW-1:IW]`. Tags increase by one per granted slot and wrap modulo DEPTH (a power of two). Occupancy grows by the number of slots granted.
- R3: `disp_stall` is high when the requested count exceeds the free slots. A stalled request allocates nothing. All DEPTH slots can be occupied at once.
- R4: Slots freed by retirement count as free in the cycle right after the retiring clock edge.
- R5: An oldest slot whose completion was reported at clock edge N retires at edge N+1. `ret_vld[0]` and its tag on `ret_tag[IW-1:0]` are valid after that edge.
- R6: A completed slot never retires while an older slot is still outstanding.
- R7: At most two slots retire per cycle. The second oldest retires (`ret_vld[1]`) only if the oldest also retires and the second is complete without a fault.
- R8: Retiring a slot that has a destination writes its result into that architectural register. Slots without a destination write nothing. When both retiring slots name the same register, the younger value remains.
- R9: A fault is held until its slot is the oldest. The next edge then raises `exc_vld` for exactly one cycle with `exc_tag` equal to that slot's tag, and no slot retires in that cycle. The faulting slot's destination is not written.
- R10: At the edge that raises `exc_vld`, the queue empties: occupancy becomes 0, results of all discarded slots are never written, and the next allocation tag is 0.
- R11: In the cycle in which the oldest slot is a fault, any dispatch request is stalled and allocates nothing.
- R12: `rd_data` presents the architectural register addressed by `rd_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_cnt | input | 2 | Number of slots requested this cycle (0 to 2) |
| disp_has_dst | input | 2 | Per requested slot: instruction writes a register |
| disp_dst | input | 2*AW | Per requested slot: destination register index |
| disp_stall | output | 1 | Request cannot be granted this cycle |
| alloc_tag | output | 2*IW | Tags the two requested slots would receive |
| occupancy | output | CW | Number of slots in use |
| fin_vld | input | NFIN | Per completion port: report valid |
| fin_idx | input | NFIN*IW | Per completion port: slot tag |
| fin_exc | input | NFIN | Per completion port: fault instead of result |
| fin_data | input | NFIN*DW | Per completion port: result value |
| ret_vld | output | 2 | Slots retired at the last edge (bit 0 oldest) |
| ret_tag | output | 2*IW | Tags of the slots on ret_vld |
| exc_vld | output | 1 | One-cycle precise exception pulse |
| exc_tag | output | IW | Tag of the faulting slot |
| rd_addr | input | AW | Architectural read address |
| rd_data | output | DW | Architectural read data |

## Verification
On every cycle, the assertions check that occupancy never exceeds DEPTH and that a stalled request leaves the allocation pointer alone. They also check that a second retirement never appears without the first, that an exception pulse is isolated, retires nothing and leaves an empty queue, and that the oldest slot is always live when the queue is not empty. Only the bench scenarios can show the data side: which value reaches which register, that a younger write to the same register wins, and that faulting and discarded slots leave the register file untouched. The bench also shows that out-of-order completions wait for the oldest, and that tags wrap and restart at zero after a flush.

// File: rtl/rq_pkg.sv
package rq_pkg;
  localparam int DISP_W = 2;
  localparam int RET_W  = 2;

  typedef enum logic [1:0] {
    OLDEST_NONE,
    OLDEST_WAIT,
    OLDEST_RETIRE,
    OLDEST_FAULT
  } oldest_state_e;
endpackage

// File: rtl/rq_ptrs.sv
module rq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    req_cnt,
  input  logic          flush,
  input  logic [1:0]    ret_en,
  output logic [IW-1:0] head_q,
  output logic [IW-1:0] tail_q,
  output logic [CW-1:0] count_q,
  output logic          stall,
  output logic [1:0]    alloc_en
);
  logic [CW-1:0] free_slots;
  logic [1:0]    alloc_n;
  logic [1:0]    ret_n;

  always_comb begin
    free_slots  = CW'(DEPTH) - count_q;
    stall       = flush || (CW'(req_cnt) > free_slots);
    alloc_en[0] = !stall && (req_cnt != 2'd0);
    alloc_en[1] = !stall && req_cnt[1];
    alloc_n     = {1'b0, alloc_en[0]} + {1'b0, alloc_en[1]};
    ret_n       = {1'b0, ret_en[0]} + {1'b0, ret_en[1]};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q  <= head_q + IW'(ret_n);
      tail_q  <= tail_q + IW'(alloc_n);
      count_q <= count_q + CW'(alloc_n) - CW'(ret_n);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count_q <= CW'(DEPTH));

  p_stall_keeps_tail_r3: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> $stable(tail_q));
endmodule

// File: rtl/rq_entries.sv
module rq_entries #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int AW    = 5,
  parameter int NFIN  = 2,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [IW-1:0]       head_q,
  input  logic [IW-1:0]       tail_q,
  input  logic [1:0]          alloc_en,
  input  logic [1:0]          disp_has_dst,
  input  logic [2*AW-1:0]     disp_dst,
  input  logic [1:0]          ret_en,
  input  logic [NFIN-1:0]     fin_vld,
  input  logic [NFIN*IW-1:0]  fin_idx,
  input  logic [NFIN-1:0]     fin_exc,
  input  logic [NFIN*DW-1:0]  fin_data,
  output logic                head_live,
  output logic [1:0]          slot_done,
  output logic [1:0]          slot_exc,
  output logic [1:0]          slot_has_dst,
  output logic [2*AW-1:0]     slot_dst,
  output logic [2*DW-1:0]     slot_data
);
  logic [DEPTH-1:0] live_q, done_q, fault_q, wdst_q;
  logic [AW-1:0]    dst_q [DEPTH];
  logic [DW-1:0]    ren_q [DEPTH];
  logic [IW-1:0]    hix [2];
  logic [IW-1:0]    tix [2];
  logic [IW-1:0]    fix [NFIN];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      hix[s] = head_q + IW'(s);
      tix[s] = tail_q + IW'(s);
    end
    for (int f = 0; f < NFIN; f++) fix[f] = fin_idx[f*IW +: IW];
  end

  // Slot status bits
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= '0;
      done_q  <= '0;
      fault_q <= '0;
      wdst_q  <= '0;
    end else if (flush) begin
      live_q  <= '0;
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      for (int f = 0; f < NFIN; f++) begin
        if (fin_vld[f] && live_q[fix[f]]) begin
          done_q[fix[f]]  <= 1'b1;
          fault_q[fix[f]] <= fin_exc[f];
        end
      end
      for (int s = 0; s < 2; s++) begin
        if (ret_en[s]) live_q[hix[s]] <= 1'b0;
      end
      for (int s = 0; s < 2; s++) begin
        if (alloc_en[s]) begin
          live_q[tix[s]]  <= 1'b1;
          done_q[tix[s]]  <= 1'b0;
          fault_q[tix[s]] <= 1'b0;
          wdst_q[tix[s]]  <= disp_has_dst[s];
        end
      end
    end
  end

  // Destination indices and rename buffers: plain storage, no reset
  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++) begin
      if (alloc_en[s]) dst_q[tix[s]] <= disp_dst[s*AW +: AW];
    end
  end

  always_ff @(posedge clk) begin
    for (int f = 0; f < NFIN; f++) begin
      if (fin_vld[f]) ren_q[fix[f]] <= fin_data[f*DW +: DW];
    end
  end

  always_comb begin
    head_live = live_q[hix[0]];
    for (int s = 0; s < 2; s++) begin
      slot_done[s]              = done_q[hix[s]];
      slot_exc[s]               = fault_q[hix[s]];
      slot_has_dst[s]           = wdst_q[hix[s]];
      slot_dst[s*AW +: AW]      = dst_q[hix[s]];
      slot_data[s*DW +: DW]     = ren_q[hix[s]];
    end
  end

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (live_q == '0));
endmodule

// File: rtl/rq_retire_sel.sv
module rq_retire_sel #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count_q,
  input  logic [1:0]    slot_done,
  input  logic [1:0]    slot_exc,
  output logic [1:0]    ret_en,
  output logic          fault
);
  import rq_pkg::*;

  oldest_state_e st;

  always_comb begin
    if (count_q == '0)       st = OLDEST_NONE;
    else if (!slot_done[0])  st = OLDEST_WAIT;
    else if (slot_exc[0])    st = OLDEST_FAULT;
    else                     st = OLDEST_RETIRE;

    fault     = (st == OLDEST_FAULT);
    ret_en[0] = (st == OLDEST_RETIRE);
    ret_en[1] = ret_en[0] && (count_q >= CW'(2)) && slot_done[1] && !slot_exc[1];
  end
endmodule

// File: rtl/rq_arch_rf.sv
module rq_arch_rf #(
  parameter int NARCH = 32,
  parameter int DW    = 32,
  localparam int AW = $clog2(NARCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      we,
  input  logic [2*AW-1:0] waddr,
  input  logic [2*DW-1:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DW-1:0]   rdata
);
  logic [DW-1:0] regs_q [NARCH];

  // Port 1 is written after port 0 so the younger slot wins a collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NARCH; i++) regs_q[i] <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (we[p]) regs_q[waddr[p*AW +: AW]] <= wdata[p*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= regs_q[raddr];
  end
endmodule

// File: rtl/rob_retire_queue.sv
module rob_retire_queue #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int NARCH = 32,
  parameter int NFIN  = 2,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int AW = $clog2(NARCH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          disp_cnt,
  input  logic [1:0]          disp_has_dst,
  input  logic [2*AW-1:0]     disp_dst,
  output logic                disp_stall,
  output logic [2*IW-1:0]     alloc_tag,
  output logic [CW-1:0]       occupancy,
  input  logic [NFIN-1:0]     fin_vld,
  input  logic [NFIN*IW-1:0]  fin_idx,
  input  logic [NFIN-1:0]     fin_exc,
  input  logic [NFIN*DW-1:0]  fin_data,
  output logic [1:0]          ret_vld,
  output logic [2*IW-1:0]     ret_tag,
  output logic                exc_vld,
  output logic [IW-1:0]       exc_tag,
  input  logic [AW-1:0]       rd_addr,
  output logic [DW-1:0]       rd_data
);
  logic [IW-1:0]  head_q, tail_q;
  logic [1:0]     alloc_en, ret_en;
  logic           fault, head_live;
  logic [1:0]     slot_done, slot_exc, slot_has_dst;
  logic [2*AW-1:0] slot_dst;
  logic [2*DW-1:0] slot_data;

  rq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst), .req_cnt(disp_cnt), .flush(fault), .ret_en(ret_en),
    .head_q(head_q), .tail_q(tail_q), .count_q(occupancy),
    .stall(disp_stall), .alloc_en(alloc_en)
  );

  rq_entries #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .NFIN(NFIN)) u_entries (
    .clk(clk), .rst(rst), .flush(fault), .head_q(head_q), .tail_q(tail_q),
    .alloc_en(alloc_en), .disp_has_dst(disp_has_dst), .disp_dst(disp_dst),
    .ret_en(ret_en), .fin_vld(fin_vld), .fin_idx(fin_idx), .fin_exc(fin_exc),
    .fin_data(fin_data), .head_live(head_live), .slot_done(slot_done),
    .slot_exc(slot_exc), .slot_has_dst(slot_has_dst), .slot_dst(slot_dst),
    .slot_data(slot_data)
  );

  rq_retire_sel #(.DEPTH(DEPTH)) u_sel (
    .count_q(occupancy), .slot_done(slot_done), .slot_exc(slot_exc),
    .ret_en(ret_en), .fault(fault)
  );

  rq_arch_rf #(.NARCH(NARCH), .DW(DW)) u_arf (
    .clk(clk), .rst(rst), .we(ret_en & slot_has_dst), .waddr(slot_dst),
    .wdata(slot_data), .raddr(rd_addr), .rdata(rd_data)
  );

  assign alloc_tag = {tail_q + IW'(1), tail_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_vld <= '0;
      ret_tag <= '0;
      exc_vld <= 1'b0;
      exc_tag <= '0;
    end else begin
      ret_vld <= ret_en;
      ret_tag <= {head_q + IW'(1), head_q};
      exc_vld <= fault;
      exc_tag <= head_q;
    end
  end

  p_ret_pair_r7: assert property (@(posedge clk) disable iff (rst)
    ret_vld[1] |-> ret_vld[0]);

  p_exc_no_ret_r9: assert property (@(posedge clk) disable iff (rst)
    exc_vld |-> (ret_vld == 2'b00));

  p_exc_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    exc_vld |=> !exc_vld);

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (rst)
    exc_vld |-> (occupancy == '0));

  p_head_live_r6: assert property (@(posedge clk) disable iff (rst)
    (occupancy != '0) |-> head_live);
endmodule

// File: tb/tb_rob_retire_queue.sv
`timescale 1ns/1ps
module tb_rob_retire_queue;
  localparam int DEPTH = 8, DW = 32, NARCH = 32, NFIN = 2;
  localparam int IW = 3, CW = 4, AW = 5;

  typedef struct packed { logic [AW-1:0] dst; logic [DW-1:0] data; } vec_t;
  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{5'd20, 32'h0000_A001}, '{5'd21, 32'h1234_5678}, '{5'd22, 32'hFFFF_FFFF},
    '{5'd23, 32'h0000_0001}, '{5'd24, 32'h8000_0000}, '{5'd25, 32'h5A5A_A5A5},
    '{5'd26, 32'h0BAD_F00D}, '{5'd27, 32'h0000_7777}, '{5'd28, 32'hC0DE_0028},
    '{5'd29, 32'h1357_9BDF}};

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] disp_cnt = '0, disp_has_dst = '0;
  logic [2*AW-1:0] disp_dst = '0;
  logic disp_stall;
  logic [2*IW-1:0] alloc_tag, ret_tag;
  logic [CW-1:0] occupancy;
  logic [NFIN-1:0] fin_vld = '0, fin_exc = '0;
  logic [NFIN*IW-1:0] fin_idx = '0;
  logic [NFIN*DW-1:0] fin_data = '0;
  logic [1:0] ret_vld;
  logic exc_vld;
  logic [IW-1:0] exc_tag;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rob_retire_queue #(.DEPTH(DEPTH), .DW(DW), .NARCH(NARCH), .NFIN(NFIN)) dut (
    .clk(clk), .rst(rst), .disp_cnt(disp_cnt), .disp_has_dst(disp_has_dst),
    .disp_dst(disp_dst), .disp_stall(disp_stall), .alloc_tag(alloc_tag),
    .occupancy(occupancy), .fin_vld(fin_vld), .fin_idx(fin_idx),
    .fin_exc(fin_exc), .fin_data(fin_data), .ret_vld(ret_vld),
    .ret_tag(ret_tag), .exc_vld(exc_vld), .exc_tag(exc_tag),
    .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    rd_addr = a;
    cyc();
    chk(req, rd_data, exp);
  endtask

  function automatic logic [IW-1:0] tg(input int base, input int k);
    return IW'((base + k) % DEPTH);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b;
    repeat (3) cyc();
    rst = 1'b0;
    // R1: reset state
    chk("R1 occupancy", 32'(occupancy), 0);
    chk("R1 ret_vld", 32'(ret_vld), 0);
    chk("R1 exc_vld", 32'(exc_vld), 0);
    chk("R1 alloc_tag", 32'(alloc_tag[IW-1:0]), 0);
    disp_cnt = 2'd2; #1;
    chk("R1 stall", 32'(disp_stall), 0);
    disp_cnt = 2'd0;
    rd_chk(5'd3, 0, "R12 reset read");

    // Vector table: single-slot dispatch, complete, retire, read back
    for (int i = 0; i < NV; i++) begin
      disp_cnt = 2'd1; disp_has_dst = 2'b01; disp_dst[AW-1:0] = VEC[i].dst; #1;
      chk("R2 tag", 32'(alloc_tag[IW-1:0]), 32'(i % DEPTH));
      cyc();
      disp_cnt = 2'd0;
      chk("R2 occupancy", 32'(occupancy), 1);
      fin_vld = 2'b01; fin_idx[IW-1:0] = IW'(i % DEPTH); fin_data[DW-1:0] = VEC[i].data;
      cyc();
      fin_vld = 2'b00;
      cyc();
      chk("R5 retire", 32'(ret_vld), 32'b01);
      chk("R5 tag", 32'(ret_tag[IW-1:0]), 32'(i % DEPTH));
      chk("R4 occupancy", 32'(occupancy), 0);
      rd_chk(VEC[i].dst, VEC[i].data, "R8 arch write");
    end

    // Fill the queue: slots k=0..7 starting at tag b
    b = NV % DEPTH;
    disp_cnt = 2'd2; disp_has_dst = 2'b11; disp_dst = {5'd5, 5'd5}; #1;
    chk("R2 pair tags", 32'(alloc_tag), 32'({tg(b, 1), tg(b, 0)}));
    cyc();
    disp_has_dst = 2'b10; disp_dst = {5'd13, 5'd0};
    cyc();
    disp_has_dst = 2'b11; disp_dst = {5'd15, 5'd14};
    cyc();
    chk("R2 occupancy six", 32'(occupancy), 6);
    disp_cnt = 2'd1; disp_has_dst = 2'b01; disp_dst = {5'd0, 5'd16};
    cyc();
    disp_cnt = 2'd2; #1;
    chk("R3 stall one free", 32'(disp_stall), 1);
    cyc();
    chk("R3 no alloc when stalled", 32'(occupancy), 7);
    disp_cnt = 2'd1; disp_dst = {5'd0, 5'd17}; #1;
    chk("R3 last slot grant", 32'(disp_stall), 0);
    cyc();
    chk("R3 full", 32'(occupancy), 8);
    #1;
    chk("R3 stall full", 32'(disp_stall), 1);
    disp_cnt = 2'd0;

    // Younger slot completes first
    fin_vld = 2'b01; fin_idx[IW-1:0] = tg(b, 1); fin_data[DW-1:0] = 32'h2222;
    cyc();
    fin_vld = 2'b00;
    cyc();
    chk("R6 no early retire", 32'(ret_vld), 0);
    fin_vld = 2'b01; fin_idx[IW-1:0] = tg(b, 0); fin_data[DW-1:0] = 32'h1111;
    cyc();
    fin_vld = 2'b00;
    disp_cnt = 2'd2; #1;
    chk("R4 stall before retire", 32'(disp_stall), 1);
    cyc();
    chk("R7 dual retire", 32'(ret_vld), 32'b11);
    chk("R7 dual tags", 32'(ret_tag), 32'({tg(b, 1), tg(b, 0)}));
    chk("R4 occupancy", 32'(occupancy), 6);
    #1;
    chk("R4 freed next cycle", 32'(disp_stall), 0);
    disp_cnt = 2'd0;
    rd_chk(5'd5, 32'h2222, "R8 younger wins");

    // Faults recorded out of order
    fin_vld = 2'b11; fin_exc = 2'b01;
    fin_idx = {tg(b, 5), tg(b, 3)}; fin_data = {32'h5555, 32'h3333};
    cyc();
    fin_vld = 2'b00; fin_exc = 2'b00;
    cyc();
    chk("R9 fault held", 32'(exc_vld), 0);
    chk("R9 nothing retires", 32'(ret_vld), 0);
    fin_vld = 2'b11; fin_idx = {tg(b, 4), tg(b, 2)}; fin_data = {32'h4444, 32'h2020};
    cyc();
    fin_vld = 2'b00;
    cyc();
    chk("R7 second blocked by fault", 32'(ret_vld), 32'b01);
    chk("R9 not yet oldest", 32'(exc_vld), 0);
    chk("R7 occupancy", 32'(occupancy), 5);
    disp_cnt = 2'd1; disp_has_dst = 2'b01; disp_dst = {5'd0, 5'd9}; #1;
    chk("R11 stall on fault", 32'(disp_stall), 1);
    cyc();
    disp_cnt = 2'd0;
    chk("R9 exception pulse", 32'(exc_vld), 1);
    chk("R9 exception tag", 32'(exc_tag), 32'(tg(b, 3)));
    chk("R9 no retire", 32'(ret_vld), 0);
    chk("R10 emptied", 32'(occupancy), 0);
    cyc();
    chk("R9 single pulse", 32'(exc_vld), 0);
    chk("R10 tag restart", 32'(alloc_tag[IW-1:0]), 0);
    chk("R11 dispatch dropped", 32'(occupancy), 0);
    rd_chk(5'd13, 0, "R9 fault not written");
    rd_chk(5'd14, 0, "R10 discarded slot");
    rd_chk(5'd15, 0, "R10 discarded slot");
    rd_chk(5'd9, 0, "R11 dropped dispatch");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule